// File: doc/BRIEF.md
# Biased Pseudo-LRU Victim Picker

This block chooses which way of a set-associative cache is overwritten when a new line must be allocated. For every set it keeps a binary tree of direction bits that approximates least-recently-used order. Access notifications steer the tree away from the touched way, but only when the access qualifies. Accesses that carry a non-temporal hint do not qualify. Accesses that are too speculative do not qualify. Prefetches qualify only when a configuration input allows it.

On an allocation request the block ranks the ways of the set by their line status, supplied by the caller. An invalid line ranks ahead of a valid one. A clean line ranks ahead of a dirty one. Next comes the line held in the fewest inner caches, and last a data line ranks ahead of an instruction line. The tree then chooses among the ways that share the best rank. After a victim is issued, the tree path is pointed away from it. A coherency fill that targets a way left invalid by an invalidation simply takes that way, and the tree is not advanced.

The victim is registered and appears with a one-cycle strobe in the cycle after the request.

Top module: `plru_victim_picker`

## Requirements
- R1: After reset every tree bit is zero. An allocation to any set that has not been touched since then returns way 0 when all ways rank equally. `victimValid` is high exactly in the cycle after a cycle with `allocValid` high, and low otherwise.
- R2: Issuing a victim points every tree bit on its path away from it. With four equally ranked ways and no other traffic, successive allocations to one set return ways 0, 2, 1, 3.
- R3: A qualifying access points the tree path of `accWay` in set `accSet` away from that way at the next clock edge.
- R4: An access with `accNonTemporal` high leaves the tree unchanged.
- R5: `accSpecLevel` uses this encoding: 0 is non-speculative and 1 means all older branches are resolved; both of these update the tree. 2 means the access lies on an unresolved branch path and 3 means it comes from a highly speculative thread; neither of these updates the tree.
- R6: An access with `accPrefetch` high updates the tree only while `cfgPrefetchUpdates` is 1.
- R7: If `allocCoherFill` is high and `wayValid[allocCoherWay]` is 0, the victim is `allocCoherWay` and the tree of that set is unchanged. If that way is valid, normal selection applies.
- R8: If any way of the request is invalid (`wayValid` bit 0), the victim is an invalid way.
- R9: If all ways are valid and at least one is clean (`wayDirty` bit 0), the victim is clean.
- R10: Among the ways left after R8 and R9, only those with the smallest inner-cache count remain candidates. Way w's count is in `wayInnerCnt[w*CNT_W +: CNT_W]`.
- R11: Among the ways left after R10, data ways (`wayIsInstr` bit 0) are preferred over instruction ways.
- R12: The final choice walks the tree from the root, where bit 0 selects the lower half. At each node it takes the side the bit selects if that side holds a candidate, and the other side otherwise.
- R13: Each set has its own tree. Updates to one set do not change the victims of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access notification present |
| accSet | input | SET_W | Set of the access |
| accWay | input | WAY_W | Way of the access |
| accNonTemporal | input | 1 | Non-temporal hint |
| accSpecLevel | input | 2 | Speculation level (encoding in R5) |
| accPrefetch | input | 1 | Access is a prefetch |
| cfgPrefetchUpdates | input | 1 | Prefetches may update the tree |
| allocValid | input | 1 | Allocation request |
| allocSet | input | SET_W | Set to allocate in |
| allocCoherFill | input | 1 | Request is a coherency-miss fill |
| allocCoherWay | input | WAY_W | Way left behind by the invalidation |
| wayValid | input | NUM_WAYS | Per-way valid |
| wayDirty | input | NUM_WAYS | Per-way dirty |
| wayInnerCnt | input | NUM_WAYS*CNT_W | Per-way inner-cache presence count |
| wayIsInstr | input | NUM_WAYS | Per-way line holds instructions |
| victimValid | output | 1 | Victim strobe |
| victimWay | output | WAY_W | Chosen way |

## Verification
A wrong tree bit is not visible when it goes wrong. It shows up at the next allocation to that set as a different way on `victimWay`, one cycle after the request. For that reason each access stimulus is followed by an allocation to the same set, whose expected way differs between the update and no-update cases. A flawed status ranking shows on the very allocation that exercises it. The status patterns are chosen so that the plain tree order would pick a different way from the biased one, so a faulty bias cannot hide behind the tree.

// File: rtl/plru_pick_pkg.sv
package plru_pick_pkg;
  typedef enum logic [1:0] {
    SPEC_RETIRED    = 2'd0,
    SPEC_RESOLVED   = 2'd1,
    SPEC_UNRESOLVED = 2'd2,
    SPEC_THREAD     = 2'd3
  } spec_level_e;

  // strobes from control to datapath
  typedef struct packed {
    logic touchEn;  // access updates the tree
    logic pickEn;   // allocation selects and advances
    logic takeEn;   // coherency fill takes the invalid way
  } strobe_t;
endpackage

// File: rtl/plru_pick_ctrl.sv
module plru_pick_ctrl
  import plru_pick_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic                accNonTemporal,
  input  logic [1:0]          accSpecLevel,
  input  logic                accPrefetch,
  input  logic                cfgPrefetchUpdates,
  input  logic                allocValid,
  input  logic                allocCoherFill,
  input  logic [WAY_W-1:0]    allocCoherWay,
  input  logic [NUM_WAYS-1:0] wayValid,
  output strobe_t             strb
);
  spec_level_e specLvl;
  logic specOk;
  logic typeOk;

  always_comb begin
    specLvl = spec_level_e'(accSpecLevel);
    specOk  = (specLvl == SPEC_RETIRED) || (specLvl == SPEC_RESOLVED);
    typeOk  = !accPrefetch || cfgPrefetchUpdates;
    strb.touchEn = accValid && !accNonTemporal && specOk && typeOk;
    strb.takeEn  = allocValid && allocCoherFill && !wayValid[allocCoherWay];
    strb.pickEn  = allocValid && !strb.takeEn;
  end

  assert_nt_no_touch_R4: assert property (@(posedge clk) disable iff (!rstN)
    accNonTemporal |-> !strb.touchEn);
  assert_spec_no_touch_R5: assert property (@(posedge clk) disable iff (!rstN)
    accSpecLevel[1] |-> !strb.touchEn);
  assert_pf_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accPrefetch && !cfgPrefetchUpdates) |-> !strb.touchEn);
  assert_one_alloc_kind_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.pickEn, strb.takeEn}));
endmodule

// File: rtl/plru_pick_dp.sv
module plru_pick_dp
  import plru_pick_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  parameter int CNT_W    = 2,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int LVL   = WAY_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [SET_W-1:0]          accSet,
  input  logic [WAY_W-1:0]          accWay,
  input  logic [SET_W-1:0]          allocSet,
  input  logic [WAY_W-1:0]          allocCoherWay,
  input  logic [NUM_WAYS-1:0]       wayValid,
  input  logic [NUM_WAYS-1:0]       wayDirty,
  input  logic [NUM_WAYS*CNT_W-1:0] wayInnerCnt,
  input  logic [NUM_WAYS-1:0]       wayIsInstr,
  output logic                      victimValid,
  output logic [WAY_W-1:0]          victimWay
);
  typedef logic [NUM_WAYS-1:1] row_t;

  row_t treeQ [NUM_SETS];
  row_t rowTouch, baseRow, rowPick, allocRow;
  logic [NUM_WAYS-1:0] tierMask, cntMask, dataMask, candMask;
  logic [CNT_W-1:0]    minCnt;
  logic [WAY_W-1:0]    pickWay;

  function automatic row_t pointAway(input row_t row, input logic [WAY_W-1:0] way);
    row_t r;
    int node;
    r = row;
    node = 1;
    for (int l = 0; l < LVL; l++) begin
      logic b;
      b = way[LVL-1-l];
      r[node] = ~b;
      node = 2 * node + int'(b);
    end
    return r;
  endfunction

  // status ranking: invalid, then clean, then fewest inner copies, then data
  always_comb begin
    if (|(~wayValid))      tierMask = ~wayValid;
    else if (|(~wayDirty)) tierMask = ~wayDirty;
    else                   tierMask = '1;
    minCnt = '1;
    for (int w = 0; w < NUM_WAYS; w++)
      if (tierMask[w] && wayInnerCnt[w*CNT_W +: CNT_W] < minCnt)
        minCnt = wayInnerCnt[w*CNT_W +: CNT_W];
    for (int w = 0; w < NUM_WAYS; w++)
      cntMask[w] = tierMask[w] && (wayInnerCnt[w*CNT_W +: CNT_W] == minCnt);
    dataMask = cntMask & ~wayIsInstr;
    candMask = (|dataMask) ? dataMask : cntMask;
  end

  // masked tree walk
  always_comb begin
    int node;
    int prefix;
    node = 1;
    prefix = 0;
    allocRow = treeQ[allocSet];
    for (int l = 0; l < LVL; l++) begin
      logic anyL, anyR, dir;
      anyL = 1'b0;
      anyR = 1'b0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        if ((w >> (LVL - l)) == prefix) begin
          if (((w >> (LVL - 1 - l)) & 1) == 0) anyL = anyL | candMask[w];
          else                                 anyR = anyR | candMask[w];
        end
      end
      if (allocRow[node]) dir = anyR ? 1'b1 : !anyL;
      else                dir = anyL ? 1'b0 : anyR;
      node   = 2 * node + int'(dir);
      prefix = 2 * prefix + int'(dir);
    end
    pickWay = prefix[WAY_W-1:0];
  end

  always_comb begin
    rowTouch = pointAway(treeQ[accSet], accWay);
    baseRow  = (strb.touchEn && accSet == allocSet) ? rowTouch : treeQ[allocSet];
    rowPick  = pointAway(baseRow, pickWay);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) treeQ[s] <= '0;
      victimValid <= 1'b0;
      victimWay   <= '0;
    end else begin
      if (strb.touchEn) treeQ[accSet] <= rowTouch;
      if (strb.pickEn)  treeQ[allocSet] <= rowPick;
      victimValid <= strb.pickEn || strb.takeEn;
      if (strb.pickEn)      victimWay <= pickWay;
      else if (strb.takeEn) victimWay <= allocCoherWay;
    end
  end

  // history for the bias checks
  logic [NUM_WAYS-1:0] prevValid, prevDirty;
  logic prevPick;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= '1;
      prevDirty <= '0;
      prevPick  <= 1'b0;
    end else begin
      prevValid <= wayValid;
      prevDirty <= wayDirty;
      prevPick  <= strb.pickEn;
    end
  end

  assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pickEn || strb.takeEn) |=> victimValid);
  assert_strobe_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pickEn || strb.takeEn) |=> !victimValid);
  assert_take_way_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeEn |=> (victimWay == $past(allocCoherWay)));
  assert_take_keeps_tree_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeEn && !strb.touchEn) |=> (treeQ[$past(allocSet)] == $past(treeQ[allocSet])));
  assert_invalid_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (victimValid && prevPick && !(&prevValid)) |-> !prevValid[victimWay]);
  assert_clean_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (victimValid && prevPick && (&prevValid) && !(&prevDirty)) |-> !prevDirty[victimWay]);
endmodule

// File: rtl/plru_victim_picker.sv
module plru_victim_picker
  import plru_pick_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  parameter int CNT_W    = 2,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      accValid,
  input  logic [SET_W-1:0]          accSet,
  input  logic [WAY_W-1:0]          accWay,
  input  logic                      accNonTemporal,
  input  logic [1:0]                accSpecLevel,
  input  logic                      accPrefetch,
  input  logic                      cfgPrefetchUpdates,
  input  logic                      allocValid,
  input  logic [SET_W-1:0]          allocSet,
  input  logic                      allocCoherFill,
  input  logic [WAY_W-1:0]          allocCoherWay,
  input  logic [NUM_WAYS-1:0]       wayValid,
  input  logic [NUM_WAYS-1:0]       wayDirty,
  input  logic [NUM_WAYS*CNT_W-1:0] wayInnerCnt,
  input  logic [NUM_WAYS-1:0]       wayIsInstr,
  output logic                      victimValid,
  output logic [WAY_W-1:0]          victimWay
);
  strobe_t strb;

  plru_pick_ctrl #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accNonTemporal(accNonTemporal),
    .accSpecLevel(accSpecLevel), .accPrefetch(accPrefetch),
    .cfgPrefetchUpdates(cfgPrefetchUpdates), .allocValid(allocValid),
    .allocCoherFill(allocCoherFill), .allocCoherWay(allocCoherWay),
    .wayValid(wayValid), .strb(strb)
  );

  plru_pick_dp #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accSet(accSet), .accWay(accWay),
    .allocSet(allocSet), .allocCoherWay(allocCoherWay), .wayValid(wayValid),
    .wayDirty(wayDirty), .wayInnerCnt(wayInnerCnt), .wayIsInstr(wayIsInstr),
    .victimValid(victimValid), .victimWay(victimWay)
  );
endmodule

// File: tb/plru_victim_picker_tb.sv
`timescale 1ns/1ps
module plru_victim_picker_tb;
  logic clk = 1'b0;
  logic rstN;
  logic accValid, accNonTemporal, accPrefetch, cfgPrefetchUpdates;
  logic [2:0] accSet, allocSet;
  logic [1:0] accWay, accSpecLevel, allocCoherWay;
  logic allocValid, allocCoherFill;
  logic [3:0] wayValid, wayDirty, wayIsInstr;
  logic [7:0] wayInnerCnt;
  logic victimValid;
  logic [1:0] victimWay;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  plru_victim_picker u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet), .accWay(accWay),
    .accNonTemporal(accNonTemporal), .accSpecLevel(accSpecLevel), .accPrefetch(accPrefetch),
    .cfgPrefetchUpdates(cfgPrefetchUpdates), .allocValid(allocValid), .allocSet(allocSet),
    .allocCoherFill(allocCoherFill), .allocCoherWay(allocCoherWay), .wayValid(wayValid),
    .wayDirty(wayDirty), .wayInnerCnt(wayInnerCnt), .wayIsInstr(wayIsInstr),
    .victimValid(victimValid), .victimWay(victimWay)
  );

  typedef struct packed {
    logic [2:0] set;
    logic       accEn;
    logic [1:0] accWay;
    logic       nt;
    logic [1:0] spec;
    logic       pf;
    logic       cfgPf;
    logic       coher;
    logic [1:0] coherWay;
    logic [3:0] valid;
    logic [3:0] dirty;
    logic [7:0] inner;
    logic [3:0] instr;
    logic [1:0] expWay;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R1 fresh set -> way 0; R2 sequence 0,2,1,3
    '{3'd0,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd0,4'd1},
    '{3'd0,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd2,4'd2},
    '{3'd0,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd1,4'd2},
    '{3'd0,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd3,4'd2},
    // R3 touch way 0
    '{3'd0,1'b1,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd2,4'd3},
    // R4 non-temporal touch of way 1 ignored
    '{3'd0,1'b1,2'd1,1'b1,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd1,4'd4},
    // R5 unresolved-branch touch ignored, then resolved touch counts
    '{3'd0,1'b1,2'd3,1'b0,2'd2,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd3,4'd5},
    '{3'd0,1'b1,2'd0,1'b0,2'd1,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd2,4'd5},
    // R6 prefetch gated by config
    '{3'd0,1'b1,2'd1,1'b0,2'd0,1'b1,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd1,4'd6},
    '{3'd0,1'b1,2'd3,1'b0,2'd0,1'b1,1'b1,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd0,4'd6},
    // R5 speculative-thread touch ignored
    '{3'd0,1'b1,2'd2,1'b0,2'd3,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd2,4'd5},
    // R8 invalid way 2 wins
    '{3'd1,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'b1011,4'h0,8'h00,4'h0,2'd2,4'd8},
    // R9 only way 3 clean
    '{3'd1,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'b0111,8'h00,4'h0,2'd3,4'd9},
    // R10 / R12 counts {3,1,1,2}: candidates 1,2; walk masks way 0
    '{3'd1,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'b11010110,4'h0,2'd1,4'd10},
    // R11 ways 2,3 instruction: root points right but is masked
    '{3'd1,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'b1100,2'd0,4'd11},
    // R7 coherency fill into invalid way 2, then tree must be unchanged
    '{3'd1,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b1,2'd2,4'b1011,4'h0,8'h00,4'h0,2'd2,4'd7},
    '{3'd1,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd2,4'd7},
    // R7 coherency fill to a valid way falls back to normal choice
    '{3'd1,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b1,2'd3,4'hF,4'h0,8'h00,4'h0,2'd1,4'd7},
    // R13 set 0 unaffected by set 1 traffic; set 5 still fresh
    '{3'd0,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd1,4'd13},
    '{3'd5,1'b0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd0,4'hF,4'h0,8'h00,4'h0,2'd0,4'd13}
  };

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearInputs();
    accValid = 1'b0; accSet = '0; accWay = '0; accNonTemporal = 1'b0;
    accSpecLevel = '0; accPrefetch = 1'b0; cfgPrefetchUpdates = 1'b0;
    allocValid = 1'b0; allocSet = '0; allocCoherFill = 1'b0; allocCoherWay = '0;
    wayValid = 4'hF; wayDirty = '0; wayInnerCnt = '0; wayIsInstr = '0;
  endtask

  task automatic plainAlloc(input logic [2:0] s, input int exp, input string req);
    allocValid = 1'b1; allocSet = s; allocCoherFill = 1'b0;
    wayValid = 4'hF; wayDirty = '0; wayInnerCnt = '0; wayIsInstr = '0;
    @(negedge clk);
    allocValid = 1'b0;
    check(req, int'(victimValid), 1, "victimValid");
    check(req, int'(victimWay), exp, "victimWay");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    clearInputs();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(victimValid), 0, "victimValid in reset");
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d row%0d", v.req, i);
      if (v.accEn) begin
        accValid = 1'b1; accSet = v.set; accWay = v.accWay; accNonTemporal = v.nt;
        accSpecLevel = v.spec; accPrefetch = v.pf; cfgPrefetchUpdates = v.cfgPf;
        @(negedge clk);
        accValid = 1'b0;
      end
      allocValid = 1'b1; allocSet = v.set; allocCoherFill = v.coher;
      allocCoherWay = v.coherWay; wayValid = v.valid; wayDirty = v.dirty;
      wayInnerCnt = v.inner; wayIsInstr = v.instr;
      @(negedge clk);
      clearInputs();
      check(tag, int'(victimValid), 1, "victimValid");
      check(tag, int'(victimWay), int'(v.expWay), "victimWay");
    end

    // R1: strobe drops when no request
    @(negedge clk);
    check("R1", int'(victimValid), 0, "victimValid idle");

    // R1: reset mid-run clears trees
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    plainAlloc(3'd0, 0, "R1 after reset");
    // R2: repeated requests without touches move on
    plainAlloc(3'd0, 2, "R2 repeat");
    plainAlloc(3'd0, 1, "R2 repeat");
    // R3: touch way 3 of set 0 then allocate; tree b1=1,b2=0,b3=1 -> touch 3 -> b1=0,b3=0 -> left b2=0 -> way0
    accValid = 1'b1; accSet = 3'd0; accWay = 2'd3;
    @(negedge clk);
    accValid = 1'b0;
    plainAlloc(3'd0, 0, "R3 touch way3");
    // R13: touching set 2 does not disturb set 3
    accValid = 1'b1; accSet = 3'd2; accWay = 2'd0;
    @(negedge clk);
    accValid = 1'b0;
    plainAlloc(3'd3, 0, "R13 other set");
    plainAlloc(3'd2, 2, "R3 touched set");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule